// File: doc/BRIEF.md
# NRZI Packet Serializer with Zero-Bit Stuffing

This block turns a stream of packet bytes into line states for a differential two-wire serial bus. Each bit time is marked by a one-cycle strobe from a rate generator outside the block. Upstream logic offers bytes with a valid flag and marks the final byte of a packet. The block first sends an eight-bit synchronisation pattern. It then sends the payload least significant bit first, in non-return-to-zero-inverted form: a zero flips the line between its two differential states, and a one leaves it where it is. After six ones in a row it inserts an extra zero so that the line keeps changing often enough for a receiver to hold lock.

A packet closes with two bit times in which both wires are low, then one bit time of the idle state. After that the drivers are released. A speed select picks which wire is high in the idle state: the plus wire at the fast rate, the minus wire at the slow rate. The bit rate itself is set by the strobe.

Top module: `nrzi_pkt_tx`

## Requirements
- R1: After reset and between packets, oe_out and se0_out are 0, dp_out/dm_out show the idle (J) state and in_ready is 0.
- R2: A packet starts on the first bit strobe that sees in_valid in the idle state. The first eight bit times carry the sync pattern 0000000 then 1, which starting from J appears on the line as K J K J K J K K.
- R3: Payload bytes are sent least significant bit first. A 0 bit flips the line between J and K, and a 1 bit keeps the line state.
- R4: After six consecutive 1 bits, an extra 0 (a line flip) is inserted. The count of ones includes the final 1 of the sync pattern and restarts after every 0, whether payload or inserted.
- R5: The insertion rule also applies after the last payload bit, so an inserted flip can come directly before the end-of-packet sequence.
- R6: End of packet is two bit times with se0_out=1 and both lines low, then one bit time of J with oe_out still 1, then oe_out returns to 0.
- R7: With low_speed=0, J is dp_out=1/dm_out=0. With low_speed=1, J is dp_out=0/dm_out=1. K is the opposite pair in each case.
- R8: in_ready pulses for one strobe cycle. It is only high on the strobe that sends the last sync bit or the last bit of a non-final byte, and the byte is taken in that cycle. It is never high in idle, during an inserted bit, or during the end-of-packet sequence.
- R9: dp_out, dm_out, se0_out and oe_out change only in the cycle after a bit strobe.
- R10: A new packet cannot begin before oe_out has been 0 for at least one bit time after the previous end of packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| low_speed | input | 1 | 1 selects slow-rate line polarity |
| in_data | input | 8 | Byte offered by upstream |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | in_data is the final byte of the packet |
| in_ready | output | 1 | Byte taken this cycle |
| dp_out | output | 1 | Level to drive on the plus wire |
| dm_out | output | 1 | Level to drive on the minus wire |
| se0_out | output | 1 | Both wires forced low |
| oe_out | output | 1 | Line drivers enabled |

## Verification
The assertions take for granted that upstream raises in_valid with a packet's first byte and keeps it high, with each next byte presented, until the final byte is taken. They also assume that low_speed only changes while oe_out is 0. The bench's driver task sets each byte before the strobe and holds it until it sees in_ready. It switches speed only after the scoreboard has drained and the line has been released. Payloads are chosen so that long runs of ones cross byte edges and end exactly on the final bit.

// File: rtl/nrzi_tx_pkg.sv
// Shared types for the NRZI packet serializer.
package nrzi_tx_pkg;
    // Packet phase of the serializer.
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SYNC,
        TX_DATA,
        TX_EOP_SE0,
        TX_EOP_J
    } tx_state_e;
endpackage

// File: rtl/nrzi_tx_stuff_cnt.sv
// Run-length counter of consecutive one bits.
// Raises stuff_due when STUFF_LEN ones have gone out in a row.
// Assumes bit_go marks each bit placed on the line and that an inserted
// bit is reported as a zero.
module nrzi_tx_stuff_cnt #(
    parameter int STUFF_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_go,
    input  logic bit_val,
    output logic stuff_due
);
    localparam int OW = $clog2(STUFF_LEN + 1);

    logic [OW-1:0] ones;

    // Count ones and restart on any zero or while the line is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ones <= '0;
        end else if (bit_go) begin
            ones <= bit_val ? ones + OW'(1) : '0;
        end
    end

    assign stuff_due = (ones == OW'(STUFF_LEN));

    // The run never grows past the stuffing limit.
    a_r4_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= OW'(STUFF_LEN));
endmodule

// File: rtl/nrzi_tx_line.sv
// Line state keeper and pin mapper.
// Holds the J/K level, flips it on each zero bit and forces J when asked.
// Maps the level to the wire pair by speed, and forces both wires low
// during single-ended zero.
// Assumes low_speed is static while a packet is on the line.
module nrzi_tx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic low_speed,
    input  logic bit_go,
    input  logic bit_val,
    input  logic to_j,
    input  logic se0_on,
    output logic dp,
    output logic dm
);
    logic lvl_j;
    logic j_dp;

    // Track line level: 1 = J, 0 = K.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_j <= 1'b1;
        end else if (to_j) begin
            lvl_j <= 1'b1;
        end else if (bit_go && !bit_val) begin
            lvl_j <= ~lvl_j;
        end
    end

    // Map the abstract level onto the two wires.
    always_comb begin
        j_dp = ~low_speed;
        if (se0_on) begin
            dp = 1'b0;
            dm = 1'b0;
        end else begin
            dp = lvl_j ? j_dp : ~j_dp;
            dm = lvl_j ? ~j_dp : j_dp;
        end
    end

    a_r7_se0_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        se0_on |-> (!dp && !dm));
    a_r7_differential: assert property (@(posedge clk) disable iff (!rst_n)
        !se0_on |-> (dp != dm));
endmodule

// File: rtl/nrzi_tx_ctrl.sv
// Packet sequencer.
// Sends the sync pattern, shifts bytes out LSB first, inserts a stuffed
// bit when told, then runs the end-of-packet sequence and releases the line.
// Assumes in_valid stays high from a packet's first byte until its final
// byte is taken.
module nrzi_tx_ctrl
    import nrzi_tx_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SYNC_LEN     = 8,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              stuff_due,
    output logic              bit_go,
    output logic              bit_val,
    output logic              to_j,
    output logic              se0_on,
    output logic              oe_on,
    output logic              run_clear
);
    localparam int CNT_MAX = (SYNC_LEN > DATA_W) ? SYNC_LEN : DATA_W;
    localparam int CW = $clog2(CNT_MAX);
    localparam int EW = (EOP_SE0_BITS > 1) ? $clog2(EOP_SE0_BITS) : 1;
    localparam logic [CW-1:0] SYNC_END = CW'(SYNC_LEN - 1);
    localparam logic [CW-1:0] DATA_END = CW'(DATA_W - 1);
    localparam logic [EW-1:0] EOP_END  = EW'(EOP_SE0_BITS - 1);

    tx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [EW-1:0]     ecnt;
    logic [DATA_W-1:0] sh;
    logic              last_f;
    logic              done;
    logic              take_sync;
    logic              take_data;

    // Byte handshake: only on the strobe that sends a byte's final bit.
    always_comb begin
        take_sync = bit_tick && (st == TX_SYNC) && (cnt == SYNC_END);
        take_data = bit_tick && (st == TX_DATA) && !stuff_due && !done
                    && (cnt == DATA_END) && !last_f;
        in_ready  = take_sync || take_data;
    end

    // Decide which bit, if any, goes out on this strobe.
    always_comb begin
        bit_go  = 1'b0;
        bit_val = 1'b0;
        case (st)
            TX_IDLE: bit_go = bit_tick && in_valid;
            TX_SYNC: begin
                bit_go  = bit_tick;
                bit_val = (cnt == SYNC_END);
            end
            TX_DATA: begin
                bit_go  = bit_tick && (stuff_due || !done);
                bit_val = stuff_due ? 1'b0 : sh[0];
            end
            default: ;
        endcase
        to_j      = bit_tick && (st == TX_EOP_SE0) && (ecnt == EOP_END);
        se0_on    = (st == TX_EOP_SE0);
        oe_on     = (st != TX_IDLE);
        run_clear = (st == TX_IDLE);
    end

    // Advance the packet phase, bit counters and shift register per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TX_IDLE;
            cnt    <= '0;
            ecnt   <= '0;
            sh     <= '0;
            last_f <= 1'b0;
            done   <= 1'b0;
        end else if (bit_tick) begin
            case (st)
                TX_IDLE: if (in_valid) begin
                    st  <= TX_SYNC;
                    cnt <= CW'(1);
                end
                TX_SYNC: if (cnt == SYNC_END) begin
                    st     <= TX_DATA;
                    cnt    <= '0;
                    sh     <= in_data;
                    last_f <= in_last;
                    done   <= 1'b0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                TX_DATA: if (stuff_due) begin
                    st <= TX_DATA;
                end else if (done) begin
                    st   <= TX_EOP_SE0;
                    ecnt <= '0;
                end else if (cnt == DATA_END) begin
                    cnt <= '0;
                    if (last_f) begin
                        done <= 1'b1;
                    end else begin
                        sh     <= in_data;
                        last_f <= in_last;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                    sh  <= sh >> 1;
                end
                TX_EOP_SE0: if (ecnt == EOP_END) begin
                    st <= TX_EOP_J;
                end else begin
                    ecnt <= ecnt + EW'(1);
                end
                TX_EOP_J: st <= TX_IDLE;
                default:  st <= TX_IDLE;
            endcase
        end
    end

    // Upstream must hold a byte whenever one is taken.
    a_r8_taken_byte_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);
    a_r8_no_take_in_eop: assert property (@(posedge clk) disable iff (!rst_n)
        se0_on |-> !in_ready);
    a_r8_no_take_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_go && stuff_due) |-> !in_ready);
endmodule

// File: rtl/nrzi_pkt_tx.sv
// NRZI packet serializer top.
// Ties the sequencer, the ones-run counter and the line mapper together.
// Assumes bit_tick is a one-cycle strobe at the chosen bit rate and that
// low_speed changes only while the line is released.
module nrzi_pkt_tx #(
    parameter int DATA_W       = 8,
    parameter int SYNC_LEN     = 8,
    parameter int STUFF_LEN    = 6,
    parameter int EOP_SE0_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              low_speed,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              dp_out,
    output logic              dm_out,
    output logic              se0_out,
    output logic              oe_out
);
    logic stuff_due;
    logic bit_go;
    logic bit_val;
    logic to_j;
    logic run_clear;

    nrzi_tx_ctrl #(
        .DATA_W       (DATA_W),
        .SYNC_LEN     (SYNC_LEN),
        .EOP_SE0_BITS (EOP_SE0_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .stuff_due (stuff_due),
        .bit_go    (bit_go),
        .bit_val   (bit_val),
        .to_j      (to_j),
        .se0_on    (se0_out),
        .oe_on     (oe_out),
        .run_clear (run_clear)
    );

    nrzi_tx_stuff_cnt #(
        .STUFF_LEN (STUFF_LEN)
    ) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (run_clear),
        .bit_go    (bit_go),
        .bit_val   (bit_val),
        .stuff_due (stuff_due)
    );

    nrzi_tx_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_speed (low_speed),
        .bit_go    (bit_go),
        .bit_val   (bit_val),
        .to_j      (to_j),
        .se0_on    (se0_out),
        .dp        (dp_out),
        .dm        (dm_out)
    );

    // Line controls only move on a strobe.
    a_r9_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(oe_out) && $stable(se0_out)));
    // Single-ended zero is followed by a driven differential state.
    a_r6_j_follows_se0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(se0_out) |-> (oe_out && (dp_out != dm_out)));
    // Release only happens after a non-SE0 bit time.
    a_r10_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_out) |-> !$past(se0_out));
endmodule

// File: tb/nrzi_pkt_tx_tb.sv
// Scoreboard bench: the driver task predicts line symbols into a queue,
// the monitor pops and compares one symbol per bit strobe.
module nrzi_pkt_tx_tb;
    localparam int DIV = 4;
    localparam int SYM_K = 0, SYM_J = 1, SYM_SE0 = 2, SYM_Z = 3;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       low_speed = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready, dp_out, dm_out, se0_out, oe_out;

    int    n_vec = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  in_pkt = 1'b0;
    logic  [3:0] snap = 4'b0010;
    int    div_cnt = 0;
    int    cyc = 0;
    bq_t   pk;

    nrzi_pkt_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(tick), .low_speed(low_speed),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .dp_out(dp_out), .dm_out(dm_out),
        .se0_out(se0_out), .oe_out(oe_out)
    );

    always #4 clk = ~clk;

    // Bit-rate strobe, one cycle in DIV.
    always @(posedge clk) begin
        div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        tick    <= (div_cnt == DIV - 1);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got cycle %0d expected done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Expected {oe, se0, dp, dm} for a symbol.
    function automatic logic [3:0] sym_bits(int s, logic ls);
        case (s)
            SYM_K:   return {2'b10, ls, ~ls};
            SYM_J:   return {2'b10, ~ls, ls};
            SYM_SE0: return 4'b1100;
            default: return {2'b00, ~ls, ls};
        endcase
    endfunction

    task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {oe,se0,dp,dm} got %b expected %b (low_speed=%0b, R7 map)",
                     tag, act, exp, low_speed);
        end
    endtask

    // Monitor: compare one symbol after each strobe edge.
    initial begin
        forever begin
            logic t;
            logic [3:0] act;
            @(posedge clk);
            t = tick;
            #2;
            act = {oe_out, se0_out, dp_out, dm_out};
            if (t && rst_n) begin
                if (!in_pkt && oe_out) in_pkt = 1'b1;
                if (in_pkt) begin
                    if (exp_q.size() == 0) begin
                        n_vec++; n_bad++;
                        $display("FAIL R10: unexpected line activity got %b expected idle", act);
                        in_pkt = 1'b0;
                    end else begin
                        int s;
                        string tg;
                        s = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check4(tg, act, sym_bits(s, low_speed));
                        if (s == SYM_Z) in_pkt = 1'b0;
                    end
                end
                snap = act;
            end
        end
    end

    // Between strobes the outputs must hold (R9).
    initial begin
        forever begin
            logic t2;
            @(posedge clk);
            t2 = tick;
            #3;
            if (!t2 && in_pkt && rst_n)
                check4("R9", {oe_out, se0_out, dp_out, dm_out}, snap);
        end
    end

    task automatic push(int s, string tg);
        exp_q.push_back(s);
        tag_q.push_back(tg);
    endtask

    // Predict the line symbols of a packet, then feed its bytes.
    task automatic send_pkt(input bq_t b);
        int line;
        int ones;
        line = SYM_J;
        for (int i = 0; i < 8; i++) begin
            if (i < 7) line = (line == SYM_J) ? SYM_K : SYM_J;
            push(line, "R2");
        end
        ones = 1;
        for (int n = 0; n < b.size(); n++) begin
            for (int k = 0; k < 8; k++) begin
                if (b[n][k]) ones++;
                else begin
                    ones = 0;
                    line = (line == SYM_J) ? SYM_K : SYM_J;
                end
                push(line, "R3");
                if (ones == 6) begin
                    ones = 0;
                    line = (line == SYM_J) ? SYM_K : SYM_J;
                    push(line, (n == b.size() - 1 && k == 7) ? "R5" : "R4");
                end
            end
        end
        push(SYM_SE0, "R6");
        push(SYM_SE0, "R6");
        push(SYM_J, "R6");
        push(SYM_Z, "R6");
        for (int n = 0; n < b.size(); n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = b[n];
            in_last  = (n == b.size() - 1);
            forever begin
                #1;
                if (in_ready) break;
                @(negedge clk);
            end
            // R8: a byte is only taken while a sync or payload bit goes out.
            n_vec++;
            if (tag_q.size() == 0 || !(tag_q[0] == "R2" || tag_q[0] == "R3")) begin
                n_bad++;
                $display("FAIL R8: byte taken during %s, expected during R2/R3 bit",
                         (tag_q.size() == 0) ? "idle" : tag_q[0]);
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || in_pkt) @(posedge clk);
        repeat (3 * DIV) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: reset state
        check4("R1", {oe_out, se0_out, dp_out, dm_out}, 4'b0010);
        n_vec++;
        if (in_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: in_ready got %b expected 0", in_ready);
        end

        // R2 R3: plain payload, LSB order
        pk = {8'hA5, 8'h01};
        send_pkt(pk);
        wait_idle();

        // R4 R8: long ones runs crossing byte edges
        pk = {8'hFF, 8'hFF, 8'h7E};
        send_pkt(pk);
        wait_idle();

        // R5: six ones end exactly on the final bit
        pk = {8'h00, 8'hFC};
        send_pkt(pk);
        wait_idle();

        // R10: back-to-back packets with valid held
        pk = {8'h3C};
        send_pkt(pk);
        pk = {8'hFE, 8'h7F};
        send_pkt(pk);
        wait_idle();

        // R7: slow-rate polarity
        low_speed = 1'b1;
        repeat (2 * DIV) @(posedge clk);
        @(negedge clk);
        check4("R7", {oe_out, se0_out, dp_out, dm_out}, 4'b0001);
        pk = {8'hFF, 8'h00, 8'hC3};
        send_pkt(pk);
        wait_idle();
        pk = {8'hF8};
        send_pkt(pk);
        wait_idle();

        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6: %0d symbols left over, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule